// File: doc/BRIEF.md
# Peripheral-to-Pin Priority Crossbar

This block routes a fixed, ranked list of 26 on-chip peripheral signals onto a bank of general-purpose port pins. Each enabled peripheral function asks for one or more signal slots. The crossbar hands out the slots in rank order. Each slot goes to the lowest-numbered pin that is neither marked skip nor set to analog mode. Pins scan from bit 0 upward, port by port. Two-wire functions take their two slots together or not at all. When the requested signals outnumber the usable pins, the lower-ranked ones are dropped and a sticky overflow flag is raised.

The pin mapping is recomputed combinationally from the configuration inputs. Pin drive values, pin drive enables, the reported per-pin signal index and the overflow flag are all registered, so a configuration change shows at the pins one clock edge later. A pin that carries no signal behaves as a plain port bit driven from its own output-latch input. Each pin's output stage is open-drain or push-pull. Inbound peripheral signals are fed back combinationally from the pin they were given.

Top module: `pin_xbar`

## Requirements
- R1: Signal indices, highest priority first: 0 uart tx, 1 uart rx, 2 can tx, 3 can rx, 4 spi clock, 5 spi miso, 6 spi mosi, 7 spi select, 8 i2c data, 9 i2c clock, 10 cmp0 sync, 11 cmp0 async, 12 cmp1 sync, 13 cmp1 async, 14 clock out, 15..20 capture/compare 0..5, 21 counter clock in, 22 timer0 in, 23 timer1 in, 24 lin tx, 25 lin rx. Group enable bits are 0 uart, 1 can, 2 spi, 3 i2c, 4 cmp0 sync, 5 cmp0 async, 6 cmp1 sync, 7 cmp1 async, 8 clock out, 9 capture/compare, 10 counter clock, 11 timer0, 12 timer1, 13 lin. `pin_map_o[p*5 +: 5]` reports the signal index on pin p, with 31 meaning none.
- R2: Each requested signal, in index order, takes the lowest-numbered free pin. A pin with its skip bit set never carries a signal.
- R3: An analog-mode pin is treated as skipped. Its drive enable is 0 and its digital read value `pin_rd_o` is 0.
- R4: With `xbar_en_i` low, every pin reports 31 and is driven from its latch bit.
- R5: Signal 7 requests a pin only when `spi_4w_i` is 1.
- R6: The pairs (0,1), (2,3), (8,9) and (24,25) are placed together. If only one free pin remains for a pair, neither signal of the pair is placed, and no later signal is placed.
- R7: If any requested signal is left unplaced while the crossbar is enabled, `ovf_o` rises one cycle later and stays at 1 until reset.
- R8: In open-drain mode (`od_i` bit = 1), a pin's drive enable is 1 only when the value is 0. In push-pull mode the pin is driven whenever its source asks to drive.
- R9: A digital pin with no signal outputs its `latch_i` bit with the drive enable at 1, subject to R8.
- R10: Pin outputs, the pin map and the overflow flag are registered: a change appears after the next rising edge. In reset all drive enables are 0, all pin outputs are 0, all map entries are 31 and `ovf_o` is 0.
- R11: A placed signal's `sig_in_o` bit follows `pin_i` of its pin combinationally. An unplaced signal reads 1.
- R12: With the capture/compare group enabled, channels 0 up to `pca_chan_i`-1 (limited to 6) request pins.

Ports (N_PINS = 16 by default; N_SIG = 26):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xbar_en_i | input | 1 | Global crossbar enable |
| grp_en_i | input | 14 | Per-function enable flags |
| spi_4w_i | input | 1 | SPI select uses a pin |
| pca_chan_i | input | 3 | Number of capture/compare channels pinned |
| skip_i | input | N_PINS | Per-pin skip bits |
| ana_i | input | N_PINS | Per-pin analog input mode |
| od_i | input | N_PINS | Per-pin open-drain (1) / push-pull (0) |
| latch_i | input | N_PINS | Port output latch per pin |
| sig_out_i | input | N_SIG | Peripheral output values |
| sig_oe_i | input | N_SIG | Peripheral output enables |
| pin_i | input | N_PINS | Pad input values |
| pin_o | output | N_PINS | Registered pin drive values |
| pin_oe_o | output | N_PINS | Registered pin drive enables |
| pin_rd_o | output | N_PINS | Digital read value per pin |
| sig_in_o | output | N_SIG | Pin values routed back to peripherals |
| pin_map_o | output | N_PINS*5 | Registered signal index per pin |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A wrong rank or free-pin count shows up one edge after the configuration is applied. A signal then reports on the wrong pin in `pin_map_o`, and the signals ranked after it shift with it. A slip in the pair rule shows up as a lone pair member on the last free pin. A broken overflow register shows up either as a flag that clears when the configuration is relaxed or as one that never rises. Output-stage faults show within one cycle as an enabled high level in open-drain mode or as an analog pin being driven.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int N_SIG = 26;
  localparam int N_GRP = 14;
  localparam int SIG_W = 5;
  localparam logic [SIG_W-1:0] SEL_NONE = '1;
  localparam int S_NSS  = 7;
  localparam int S_CEX0 = 15;
  // lower member of each two-wire function
  localparam logic [N_SIG-1:0] PAIR_LO = N_SIG'((1 << 0) | (1 << 2) | (1 << 8) | (1 << 24));
  localparam int G_UART = 0, G_CAN = 1, G_SPI = 2, G_I2C = 3, G_CP0 = 4, G_CP0A = 5,
                 G_CP1 = 6, G_CP1A = 7, G_CLK = 8, G_PCA = 9, G_ECI = 10, G_T0 = 11,
                 G_T1 = 12, G_LIN = 13;
endpackage

// File: rtl/xbar_req.sv
module xbar_req
  import pin_xbar_pkg::*;
(
  input  logic [N_GRP-1:0] grp_en_i,
  input  logic             spi_4w_i,
  input  logic [2:0]       pca_chan_i,
  output logic [N_SIG-1:0] req_o
);
  always_comb begin
    req_o     = '0;
    req_o[0]  = grp_en_i[G_UART];
    req_o[1]  = grp_en_i[G_UART];
    req_o[2]  = grp_en_i[G_CAN];
    req_o[3]  = grp_en_i[G_CAN];
    req_o[4]  = grp_en_i[G_SPI];
    req_o[5]  = grp_en_i[G_SPI];
    req_o[6]  = grp_en_i[G_SPI];
    req_o[S_NSS] = grp_en_i[G_SPI] & spi_4w_i;
    req_o[8]  = grp_en_i[G_I2C];
    req_o[9]  = grp_en_i[G_I2C];
    req_o[10] = grp_en_i[G_CP0];
    req_o[11] = grp_en_i[G_CP0A];
    req_o[12] = grp_en_i[G_CP1];
    req_o[13] = grp_en_i[G_CP1A];
    req_o[14] = grp_en_i[G_CLK];
    for (int k = 0; k < 6; k++)
      req_o[S_CEX0+k] = grp_en_i[G_PCA] && (int'(pca_chan_i) > k);
    req_o[21] = grp_en_i[G_ECI];
    req_o[22] = grp_en_i[G_T0];
    req_o[23] = grp_en_i[G_T1];
    req_o[24] = grp_en_i[G_LIN];
    req_o[25] = grp_en_i[G_LIN];
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic                         en_i,
  input  logic [N_SIG-1:0]             req_i,
  input  logic [N_PINS-1:0]            skip_i,
  input  logic [N_PINS-1:0]            ana_i,
  output logic [N_PINS-1:0][SIG_W-1:0] sel_o,
  output logic                         ovf_o
);
  localparam int CW = $clog2(N_SIG + N_PINS + 2);

  logic [CW-1:0]     rank  [N_SIG];
  logic [CW-1:0]     frank [N_PINS];
  logic [N_PINS-1:0] free;
  logic [N_SIG-1:0]  placed;
  logic [CW-1:0]     cnt, nfree;

  always_comb begin
    cnt = '0;
    for (int s = 0; s < N_SIG; s++) begin
      rank[s] = cnt;
      cnt     = cnt + CW'(req_i[s]);
    end
    cnt = '0;
    for (int p = 0; p < N_PINS; p++) begin
      free[p]  = !skip_i[p] && !ana_i[p];
      frank[p] = cnt;
      cnt      = cnt + CW'(free[p]);
    end
    nfree = cnt;
    // a pair head needs room for its partner as well
    for (int s = 0; s < N_SIG; s++)
      placed[s] = en_i && req_i[s] && (rank[s] < nfree) &&
                  (!PAIR_LO[s] || (rank[s] + CW'(1) < nfree));
    for (int p = 0; p < N_PINS; p++) begin
      sel_o[p] = SEL_NONE;
      if (free[p])
        for (int s = 0; s < N_SIG; s++)
          if (placed[s] && rank[s] == frank[p]) sel_o[p] = SIG_W'(s);
    end
    ovf_o = en_i && |(req_i & ~placed);
  end
endmodule

// File: rtl/xbar_pad.sv
module xbar_pad (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic assigned_i,
  input  logic per_d_i,
  input  logic per_oe_i,
  input  logic latch_i,
  input  logic od_i,
  input  logic ana_i,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic pin_rd_o
);
  logic d, oe_req, oe_n;

  always_comb begin
    d      = assigned_i ? per_d_i  : latch_i;
    oe_req = assigned_i ? per_oe_i : 1'b1;
    if (ana_i)     oe_n = 1'b0;
    else if (od_i) oe_n = oe_req & ~d;
    else           oe_n = oe_req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o    <= 1'b0;
      pin_oe_o <= 1'b0;
    end else begin
      pin_o    <= ana_i ? 1'b0 : d;
      pin_oe_o <= oe_n;
    end
  end

  assign pin_rd_o = ana_i ? 1'b0 : pin_i;

  a_r3_analog_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ana_i |=> !pin_oe_o);
  a_r8_od_no_high_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_i && !ana_i) |=> !(pin_oe_o && pin_o));
  a_r9_latch_pp_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!assigned_i && !od_i && !ana_i) |=> (pin_oe_o && pin_o == $past(latch_i)));
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xbar_en_i,
  input  logic [N_GRP-1:0]        grp_en_i,
  input  logic                    spi_4w_i,
  input  logic [2:0]              pca_chan_i,
  input  logic [N_PINS-1:0]       skip_i,
  input  logic [N_PINS-1:0]       ana_i,
  input  logic [N_PINS-1:0]       od_i,
  input  logic [N_PINS-1:0]       latch_i,
  input  logic [N_SIG-1:0]        sig_out_i,
  input  logic [N_SIG-1:0]        sig_oe_i,
  input  logic [N_PINS-1:0]       pin_i,
  output logic [N_PINS-1:0]       pin_o,
  output logic [N_PINS-1:0]       pin_oe_o,
  output logic [N_PINS-1:0]       pin_rd_o,
  output logic [N_SIG-1:0]        sig_in_o,
  output logic [N_PINS*SIG_W-1:0] pin_map_o,
  output logic                    ovf_o
);
  logic [N_SIG-1:0]             req;
  logic [N_PINS-1:0][SIG_W-1:0] sel_c, map_q;
  logic                         ovf_c, ovf_q;
  logic [N_PINS-1:0]            per_d, per_oe;

  xbar_req u_req (
    .grp_en_i  (grp_en_i),
    .spi_4w_i  (spi_4w_i),
    .pca_chan_i(pca_chan_i),
    .req_o     (req)
  );

  xbar_alloc #(.N_PINS(N_PINS)) u_alloc (
    .en_i  (xbar_en_i),
    .req_i (req),
    .skip_i(skip_i),
    .ana_i (ana_i),
    .sel_o (sel_c),
    .ovf_o (ovf_c)
  );

  always_comb begin
    for (int p = 0; p < N_PINS; p++) begin
      per_d[p]  = 1'b0;
      per_oe[p] = 1'b0;
      for (int s = 0; s < N_SIG; s++)
        if (sel_c[p] == SIG_W'(s)) begin
          per_d[p]  = sig_out_i[s];
          per_oe[p] = sig_oe_i[s];
        end
    end
    for (int s = 0; s < N_SIG; s++) begin
      sig_in_o[s] = 1'b1;
      for (int p = 0; p < N_PINS; p++)
        if (sel_c[p] == SIG_W'(s)) sig_in_o[s] = pin_i[p];
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pad
    xbar_pad u_pad (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .assigned_i(sel_c[p] != SEL_NONE),
      .per_d_i   (per_d[p]),
      .per_oe_i  (per_oe[p]),
      .latch_i   (latch_i[p]),
      .od_i      (od_i[p]),
      .ana_i     (ana_i[p]),
      .pin_i     (pin_i[p]),
      .pin_o     (pin_o[p]),
      .pin_oe_o  (pin_oe_o[p]),
      .pin_rd_o  (pin_rd_o[p])
    );

    a_r2_skip_pin_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (skip_i[p] || ana_i[p]) |=> (map_q[p] == SEL_NONE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= {N_PINS{SEL_NONE}};
      ovf_q <= 1'b0;
    end else begin
      map_q <= sel_c;
      ovf_q <= ovf_q | ovf_c;
    end
  end

  assign pin_map_o = map_q;
  assign ovf_o     = ovf_q;

  logic nss_seen;
  always_comb begin
    nss_seen = 1'b0;
    for (int p = 0; p < N_PINS; p++)
      if (map_q[p] == SIG_W'(S_NSS)) nss_seen = 1'b1;
  end

  a_r4_off_no_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xbar_en_i |=> (map_q == {N_PINS{SEL_NONE}}));
  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r5_nss_4wire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_4w_i |=> !nss_seen);
endmodule

// File: tb/tb_pin_xbar.sv
module tb_pin_xbar;
  localparam int NP = 16;
  localparam int NS = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          xbar_en = 1'b0;
  logic [13:0]   grp_en = '0;
  logic          spi_4w = 1'b0;
  logic [2:0]    pca_chan = '0;
  logic [NP-1:0] skip = '0, ana = '0, od = '0, latch = '0, pin_in = '0;
  logic [NS-1:0] sig_out = '0, sig_oe = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_rd;
  logic [NS-1:0] sig_in;
  logic [NP*5-1:0] pin_map;
  logic          ovf;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pin_xbar #(.N_PINS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .xbar_en_i(xbar_en), .grp_en_i(grp_en),
    .spi_4w_i(spi_4w), .pca_chan_i(pca_chan), .skip_i(skip), .ana_i(ana),
    .od_i(od), .latch_i(latch), .sig_out_i(sig_out), .sig_oe_i(sig_oe),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .pin_rd_o(pin_rd),
    .sig_in_o(sig_in), .pin_map_o(pin_map), .ovf_o(ovf)
  );

  function automatic int mp(int p);
    return int'(pin_map[p*5 +: 5]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    xbar_en = 0; grp_en = '0; spi_4w = 0; pca_chan = '0;
    skip = '0; ana = '0; od = '0; latch = '0; pin_in = '0;
    sig_out = '0; sig_oe = '0;
    #10;
    @(negedge clk);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #10;
    chk("R10 reset oe", int'(pin_oe), 0);
    chk("R10 reset out", int'(pin_out), 0);
    chk("R10 reset map", int'(pin_map == '1), 1);
    chk("R10 reset ovf", int'(ovf), 0);
    do_reset();
  endtask

  task automatic t_basic();
    xbar_en = 1; grp_en[0] = 1; grp_en[2] = 1;
    #1 chk("R10 map before edge", mp(0), 31);
    step();
    chk("R1 pin0 uart tx", mp(0), 0);
    chk("R1 pin1 uart rx", mp(1), 1);
    chk("R2 pin2 spi clk", mp(2), 4);
    chk("R2 pin4 mosi", mp(4), 6);
    chk("R5 3-wire no select", mp(5), 31);
    spi_4w = 1;
    step();
    chk("R5 4-wire select", mp(5), 7);
  endtask

  task automatic t_skip();
    do_reset();
    xbar_en = 1; grp_en[0] = 1; grp_en[4] = 1;
    skip[0] = 1; ana[2] = 1; pin_in[2] = 1; pin_in[5] = 1;
    step();
    chk("R2 skipped pin0", mp(0), 31);
    chk("R2 pin1 uart tx", mp(1), 0);
    chk("R3 analog pin2 empty", mp(2), 31);
    chk("R3 pin3 uart rx", mp(3), 1);
    chk("R2 pin4 cmp0", mp(4), 10);
    chk("R3 analog oe", int'(pin_oe[2]), 0);
    chk("R3 analog read", int'(pin_rd[2]), 0);
    chk("R3 digital read", int'(pin_rd[5]), 1);
  endtask

  task automatic t_pair();
    do_reset();
    xbar_en = 1; grp_en[0] = 1; grp_en[3] = 1; grp_en[4] = 1;
    skip = '1; skip[2:0] = '0;
    step();
    chk("R6 pin0 uart tx", mp(0), 0);
    chk("R6 pin1 uart rx", mp(1), 1);
    chk("R6 pin2 no split pair", mp(2), 31);
    chk("R7 ovf set", int'(ovf), 1);
    skip = '0;
    step();
    chk("R6 pair placed when room", mp(2), 8);
    chk("R6 partner", mp(3), 9);
    chk("R7 ovf sticky", int'(ovf), 1);
    do_reset();
    chk("R7 ovf cleared by reset", int'(ovf), 0);
  endtask

  task automatic t_drive();
    do_reset();
    xbar_en = 1; grp_en[0] = 1;
    sig_out[0] = 1; sig_oe[0] = 1; sig_oe[1] = 0;
    latch[5] = 1;
    step();
    chk("R8 pp high value", int'(pin_out[0]), 1);
    chk("R8 pp high oe", int'(pin_oe[0]), 1);
    chk("R8 peripheral oe low", int'(pin_oe[1]), 0);
    chk("R9 latch value", int'(pin_out[5]), 1);
    chk("R9 latch oe", int'(pin_oe[5]), 1);
    od[0] = 1; od[5] = 1;
    step();
    chk("R8 od high released", int'(pin_oe[0]), 0);
    chk("R9 od latch released", int'(pin_oe[5]), 0);
    sig_out[0] = 0;
    step();
    chk("R8 od low driven", int'(pin_oe[0]), 1);
    chk("R8 od low value", int'(pin_out[0]), 0);
  endtask

  task automatic t_input();
    do_reset();
    xbar_en = 1; grp_en[0] = 1;
    pin_in = '0;
    #1 chk("R11 rx follows pin low", int'(sig_in[1]), 0);
    pin_in[1] = 1;
    #1 chk("R11 rx follows pin high", int'(sig_in[1]), 1);
    chk("R11 unplaced reads 1", int'(sig_in[2]), 1);
  endtask

  task automatic t_off();
    do_reset();
    xbar_en = 1; grp_en[0] = 1; sig_out[0] = 1; sig_oe[0] = 1;
    step();
    xbar_en = 0; latch[0] = 0;
    step();
    chk("R4 off map", mp(0), 31);
    chk("R4 off latch value", int'(pin_out[0]), 0);
    chk("R4 off latch oe", int'(pin_oe[0]), 1);
    chk("R4 off no ovf", int'(ovf), 0);
  endtask

  task automatic t_pca();
    do_reset();
    xbar_en = 1; grp_en[9] = 1; pca_chan = 3'd2;
    step();
    chk("R12 cex0", mp(0), 15);
    chk("R12 cex1", mp(1), 16);
    chk("R12 cex2 off", mp(2), 31);
    pca_chan = 3'd7;
    step();
    chk("R12 cex5", mp(5), 20);
    chk("R12 capped at 6", mp(6), 31);
  endtask

  task automatic t_prio();
    do_reset();
    xbar_en = 1; grp_en = '1; spi_4w = 1; pca_chan = 3'd6;
    step();
    for (int p = 0; p < NP; p++) chk("R1 full order", mp(p), p);
    chk("R7 ovf full", int'(ovf), 1);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_skip();
    t_pair();
    t_drive();
    t_input();
    t_off();
    t_pca();
    t_prio();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule